// File: doc/BRIEF.md
# Flash Converter Thermometer Encoder

This block is the digital back end of a two-step flash converter. A bank of comparators produces a 127-bit thermometer word, with bit 1 as the lowest level and bit 127 as the highest. A separate comparator decides which half of the input range the sample falls in. The same thermometer sweep, from all zeros to all ones, is reused for both halves, and the half-range bit tells them apart.

The encoder first turns the thermometer word into a 7-bit Gray code. It uses a flat layer of AND terms with one inverted input each, and these terms are ORed together. Each thermometer bit feeds exactly one Gray bit, so one misplaced comparator output disturbs at most one Gray bit. A chain of XOR gates then turns the Gray code into binary.

The 7 binary bits and the half-range bit are captured together on each falling clock edge into an 8-bit output register. The half-range bit goes in the top position. The output therefore has one register stage of latency. An active-low asynchronous reset clears the register. The converter delivers a new sample on every falling edge, so the ports carry no valid/ready handshake and there is no back-pressure.

Top module: `flash_code_encoder`

## Requirements
- R1: While `rst_n` is low, `code_o` is 0. The clear acts at once and does not wait for a clock edge.
- R2: `code_o[7]` equals the `msb_i` value sampled at the most recent falling edge of `clk`.
- R3: When `therm_i` is a valid thermometer word with bits 1..n set and all other bits clear (n from 0 to 127), `code_o[6:0]` equals n after the next falling edge.
- R4: An all-zero `therm_i` gives `code_o[6:0]` = 0, and an all-one `therm_i` gives 127. This holds for either value of `msb_i`.
- R5: The output changes only on a falling edge of `clk`. A change of inputs between a falling edge and the next rising edge does not appear at `code_o` until the following falling edge.
- R6: Define gray(x) = x XOR (x >> 1). Take a valid thermometer word at level L and flip a single bit p. Then gray(`code_o[6:0]`) XOR gray(L) is either 0 or has only bit k set, where k is the number of trailing zeros of p.
- R7: When the inputs are held constant, `code_o` stays constant from one falling edge to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; the register updates on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| therm_i | input | 127 | Thermometer word `[127:1]`; bit i is set when the input exceeds level i |
| msb_i | input | 1 | Half-range decision from the separate comparator |
| code_o | output | 8 | Registered result: `{msb, binary level}` |

## Verification
The main function is tried with every one of the 128 thermometer levels under both half-range values. This separates a wrong Gray term, a broken XOR chain or a misplaced top bit from correct behaviour, because any of these faults moves at least one level away from its count. A small vector table adds chosen boundary levels: 0, 1, 63, 64, 127, and alternating bit patterns in the binary result. Single-bit bubbles are then injected at every position around several levels. These show whether one corrupted comparator output spreads into more than its own Gray bit. Directed tests apply input changes between edges and assert reset mid-run, which separates rising-edge or combinational capture from the intended falling-edge register.

// File: rtl/flash_enc_pkg.sv
package flash_enc_pkg;

  // Number of AND terms that feed Gray bit k when there are therm_w levels.
  // Term j covers the level window [2^k + j*2^(k+2), 3*2^k + j*2^(k+2)).
  function automatic int term_count(input int k, input int therm_w);
    int start;
    int step;
    start = 1 << k;
    step  = 1 << (k + 2);
    if (start > therm_w) return 0;
    return ((therm_w - start) / step) + 1;
  endfunction

endpackage

// File: rtl/therm_to_gray.sv
module therm_to_gray #(
  parameter int GRAY_W  = 7,
  parameter int THERM_W = (1 << GRAY_W) - 1
) (
  input  logic [THERM_W:1]  therm,
  output logic [GRAY_W-1:0] gray
);
  import flash_enc_pkg::*;

  // Every thermometer index i = odd * 2^k feeds only Gray bit k:
  // as the rising edge of a window when i mod 2^(k+2) == 2^k,
  // otherwise as the inverted falling edge.
  for (genvar k = 0; k < GRAY_W; k++) begin : g_bit
    localparam int NT = term_count(k, THERM_W);
    logic [NT-1:0] terms;
    for (genvar j = 0; j < NT; j++) begin : g_term
      localparam int LO = (1 << k) + j * (1 << (k + 2));
      localparam int HI = LO + (1 << (k + 1));
      if (HI <= THERM_W) begin : g_window
        assign terms[j] = therm[LO] & ~therm[HI];
      end else begin : g_open
        assign terms[j] = therm[LO];
      end
    end
    assign gray[k] = |terms;
  end

endmodule

// File: rtl/gray_to_bin.sv
module gray_to_bin #(
  parameter int W = 7
) (
  input  logic [W-1:0] gray,
  output logic [W-1:0] bin
);
  always_comb begin
    bin[W-1] = gray[W-1];
    for (int k = W - 2; k >= 0; k--) begin
      bin[k] = bin[k+1] ^ gray[k];
    end
  end
endmodule

// File: rtl/flash_code_encoder.sv
module flash_code_encoder #(
  parameter int GRAY_W = 7,
  localparam int THERM_W = (1 << GRAY_W) - 1,
  localparam int CODE_W  = GRAY_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [THERM_W:1]  therm_i,
  input  logic              msb_i,
  output logic [CODE_W-1:0] code_o
);
  logic [GRAY_W-1:0] gray_w;
  logic [GRAY_W-1:0] bin_w;

  therm_to_gray #(.GRAY_W(GRAY_W), .THERM_W(THERM_W)) u_t2g (
    .therm (therm_i),
    .gray  (gray_w)
  );

  gray_to_bin #(.W(GRAY_W)) u_g2b (
    .gray (gray_w),
    .bin  (bin_w)
  );

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) code_o <= '0;
    else        code_o <= {msb_i, bin_w};
  end
endmodule

// File: rtl/flash_code_encoder_chk.sv
module flash_code_encoder_chk #(
  parameter int GRAY_W = 7,
  localparam int THERM_W = (1 << GRAY_W) - 1,
  localparam int CODE_W  = GRAY_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [THERM_W:1]  therm_i,
  input logic              msb_i,
  input logic [CODE_W-1:0] code_o
);
  logic              is_therm;
  logic [GRAY_W-1:0] ones_n;

  always_comb begin
    is_therm = ((therm_i & (therm_i + 1'b1)) == '0);
    ones_n   = GRAY_W'($countones(therm_i));
  end

  // R2
  msb_path_chk: assert property (@(negedge clk) disable iff (!rst_n)
    1'b1 |=> (code_o[GRAY_W] == $past(msb_i)));

  // R3
  level_count_chk: assert property (@(negedge clk) disable iff (!rst_n)
    is_therm |=> (code_o[GRAY_W-1:0] == $past(ones_n)));

  // R4
  full_scale_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (&therm_i) |=> (&code_o[GRAY_W-1:0]));

  // R7
  hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(therm_i) && $stable(msb_i)) |=> $stable(code_o));

endmodule

bind flash_code_encoder flash_code_encoder_chk #(.GRAY_W(GRAY_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .therm_i (therm_i),
  .msb_i   (msb_i),
  .code_o  (code_o)
);

// File: tb/flash_code_encoder_bench.sv
module flash_code_encoder_bench;
  localparam int GW = 7;
  localparam int TW = (1 << GW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW:1]   therm = '0;
  logic          msb = 1'b0;
  logic [GW:0]   code;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // {msb, level, expected code}
  localparam logic [15:0] VEC [11] = '{
    {1'b0, 7'd0,   8'd0},   {1'b1, 7'd0,   8'd128},
    {1'b0, 7'd1,   8'd1},   {1'b1, 7'd1,   8'd129},
    {1'b0, 7'd63,  8'd63},  {1'b0, 7'd64,  8'd64},
    {1'b1, 7'd64,  8'd192}, {1'b0, 7'd126, 8'd126},
    {1'b1, 7'd127, 8'd255}, {1'b0, 7'd85,  8'd85},
    {1'b1, 7'd42,  8'd170}
  };

  flash_code_encoder #(.GRAY_W(GW)) u_flash_code_encoder (
    .clk     (clk),
    .rst_n   (rst_n),
    .therm_i (therm),
    .msb_i   (msb),
    .code_o  (code)
  );

  always #5 clk = ~clk;

  function automatic logic [TW:1] level_word(input int lvl);
    logic [TW:1] v;
    for (int i = 1; i <= TW; i++) v[i] = (i <= lvl);
    return v;
  endfunction

  function automatic logic [GW-1:0] to_gray(input logic [GW-1:0] x);
    return x ^ (x >> 1);
  endfunction

  task automatic check(input string req, input logic [GW:0] act, input logic [GW:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive after a rising edge, sample after the next rising edge (falling edge between)
  task automatic apply(input logic m, input logic [TW:1] t);
    @(posedge clk); #1;
    msb = m; therm = t;
    @(posedge clk); #1;
  endtask

  initial begin
    #1;
    check("R1 reset", code, '0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // table walk
    foreach (VEC[i]) begin
      apply(VEC[i][15], level_word(int'(VEC[i][14:8])));
      check("R3/R4 table", code, VEC[i][7:0]);
    end

    // all levels, both halves (R2, R3)
    for (int m = 0; m < 2; m++) begin
      for (int lvl = 0; lvl <= TW; lvl++) begin
        apply(m[0], level_word(lvl));
        check(m == 0 ? "R3 sweep low" : "R2 sweep high", code, {m[0], lvl[GW-1:0]});
      end
    end

    // R4 extremes with both halves
    apply(1'b0, '1); check("R4 full low",  code, 8'd127);
    apply(1'b1, '0); check("R4 zero high", code, 8'd128);

    // R6 single-bit bubbles
    begin
      int lv[5] = '{0, 37, 64, 100, 127};
      foreach (lv[q]) begin
        for (int p = 1; p <= TW; p++) begin
          logic [TW:1]   t;
          logic [GW-1:0] diff;
          int            tz;
          t = level_word(lv[q]);
          t[p] = ~t[p];
          apply(1'b0, t);
          diff = to_gray(code[GW-1:0]) ^ to_gray(lv[q][GW-1:0]);
          tz = 0;
          while (((p >> tz) & 1) == 0) tz++;
          n_run++;
          if (!(diff == '0 || diff == (GW'(1) << tz))) begin
            n_fail++;
            $display("FAIL R6 level=%0d bit=%0d actual_diff=%b expected_diff=0 or %b",
                     lv[q], p, diff, GW'(1) << tz);
          end
        end
      end
    end

    // R5: change inputs after a falling edge, before the rising edge
    apply(1'b0, level_word(10));
    check("R5 setup", code, 8'd10);
    @(negedge clk); #1;
    msb = 1'b1; therm = level_word(20);
    @(posedge clk); #1;
    check("R5 no early update", code, 8'd10);
    @(negedge clk); #1;
    check("R5 falling edge update", code, 8'd148);

    // R7: hold
    repeat (3) begin
      @(negedge clk); #1;
      check("R7 hold", code, 8'd148);
    end

    // R1: asynchronous reset mid-run
    apply(1'b1, '1);
    check("R1 pre-reset", code, 8'd255);
    #2 rst_n = 1'b0;
    #1 check("R1 async clear", code, '0);
    @(negedge clk); #1;
    check("R1 held in reset", code, '0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 release", code, 8'd255);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule